// File: doc/BRIEF.md
# Pulse-Width Feedback Tracking Converter Core

This block is the digital half of an analog-to-digital converter assembled from a pulse-width output, an external low-pass filter with buffer, and an external voltage comparator. A free-running timer produces the pulse train. The timer period comes from `period_i`. The high time equals the current trial code. The filtered trial voltage is compared outside the block with the voltage being measured. The single comparator bit fed back on `cmp_i` is the only information the core receives about the input.

After reset, and after every `start_i`, the core runs a full binary search that starts at mid-scale and takes one trial per code bit. It then switches to a tracking mode. In this mode it probes one LSB away from the retained code and doubles the step while the input keeps moving the same way. A slowly drifting input therefore costs only a few trials per update instead of a full search. Each trial holds its duty code for `settle_i+1` complete periods so the filter can settle. The result and a one-cycle strobe are updated only when the code is known to lie within one LSB of the input.

Top module: `pwm_sar_tracker`

## Requirements
- R1: The counter runs from 0 to `period_i` and then restarts, so one period lasts `period_i+1` clocks. `pwm_o` is high in a period for exactly as many clocks as the duty code, starting in the counter-0 clock.
- R2: The duty code changes only on the last clock of a period. `pwm_o` rises only in the first clock of a period.
- R3: While `rst_ni` is low, `pwm_o`, `valid_o` and `result_o` are all zero.
- R4: A full search sets the first trial to 2^(W-1). Encoding: `cmp_i`=1 means the filtered trial is above the input. Each trial's increment is kept when `cmp_i` is 0 and dropped when it is 1. The next increment is half the last. After W trials `result_o` equals the input code.
- R5: Each trial lasts `settle_i+1` periods. The comparator passes through a two-flop synchroniser and is used on the last clock of the window. After reset, the first search result strobes (`period_i`+1)*(1+W*(`settle_i`+1)) clocks after release.
- R6: Tracking starts upward with a weight of 1 LSB. The weight doubles on each trial that continues in the same direction. A downward move follows the same rule.
- R7: When a trial contradicts the current direction, the direction flips and the weight returns to 1. A flip at weight 1 strobes a result: the code that was not above the input. With a constant input the core strobes once per trial window.
- R8: After a flip at a weight above 1, the weight stays at 1 until the next flip at weight 1. This keeps overshoot from cycling.
- R9: Trial codes are clamped to the range 0 to `period_i`. An input equal to `period_i` gives `result_o` = `period_i` on every window.
- R10: `start_i` causes a full search that begins at the next period end. The search's result strobes after the same count as in R5, measured from the clock after `start_i`.
- R11: `valid_o` is a one-clock pulse issued together with each `result_o` update. `result_o` holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a fresh full search |
| period_i | input | CNT_W | Last counter value of a period |
| settle_i | input | SET_W | Extra periods per trial window |
| cmp_i | input | 1 | Comparator: 1 when the filtered trial is above the input |
| pwm_o | output | 1 | Pulse-width output |
| result_o | output | CNT_W | Conversion result |
| valid_o | output | 1 | One-clock strobe on each result update |

## Verification
The bench builds the core with 6-bit codes, a period register of 63 (full scale), and a settle value of 2. With these values a complete search takes 1216 clocks and a tracking window takes 192 clocks. This puts both saturation limits, large input jumps, overshoot recovery and a restart in the middle of tracking within one short run. The bench closes the loop with a modelled filter. The filter counts the high clocks of each completed period and compares that count with the stimulus code. A behavioural model predicts `pwm_o`, `result_o` and `valid_o` on every clock.

// File: rtl/pwm_sar_pkg.sv
package pwm_sar_pkg;
  typedef enum logic {
    MODE_SEARCH = 1'b0,
    MODE_TRACK  = 1'b1
  } conv_mode_e;
endpackage

// File: rtl/pwm_sar_sync.sv
module pwm_sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_sar_timer.sv
module pwm_sar_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_next_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic             pwm_q;

  // >= so a period lowered below the count still ends the period
  assign wrap_o = (cnt_q >= period_i);
  assign cnt_d  = wrap_o ? '0 : cnt_q + 1'b1;
  // shadow load only at period end: no runt pulses
  assign duty_d = wrap_o ? duty_next_i : duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      duty_q <= duty_d;
      pwm_q  <= (cnt_d < duty_d);
    end
  end

  assign duty_o = duty_q;
  assign pwm_o  = pwm_q;
endmodule

// File: rtl/pwm_sar_ctrl.sv
module pwm_sar_ctrl
  import pwm_sar_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SET_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [SET_W-1:0] settle_i,
  output logic [CNT_W-1:0] trial_next_o,
  output logic [CNT_W-1:0] step_o,
  output logic             decide_o,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W-1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  conv_mode_e       mode_q, mode_n;
  logic [CNT_W-1:0] acc_q, acc_n;
  logic [CNT_W-1:0] step_q, step_n;
  logic [CNT_W-1:0] trial_q, trial_n;
  logic [CNT_W-1:0] result_q, result_n;
  logic [SET_W-1:0] wcnt_q;
  logic             up_q, up_n;
  logic             grow_q, grow_n;
  logic             pend_q;
  logic             valid_q, valid_n;
  logic             apply, decide, cont;
  logic [CNT_W-1:0] dbl;
  logic [CNT_W:0]   sum;

  assign apply  = wrap_i & pend_q;
  assign decide = wrap_i & ~pend_q & (wcnt_q >= settle_i);
  assign dbl    = step_q[CNT_W-1] ? step_q : (step_q << 1);
  // tracking continues when an upward trial was not above, or a downward one was
  assign cont   = up_q ^ cmp_i;

  always_comb begin
    acc_n    = acc_q;
    step_n   = step_q;
    up_n     = up_q;
    grow_n   = grow_q;
    mode_n   = mode_q;
    result_n = result_q;
    valid_n  = 1'b0;
    if (apply) begin
      acc_n  = '0;
      step_n = MID;
      up_n   = 1'b1;
      grow_n = 1'b1;
      mode_n = MODE_SEARCH;
    end else if (decide) begin
      if (mode_q == MODE_SEARCH) begin
        acc_n = cmp_i ? acc_q : trial_q;
        if (step_q == ONE) begin
          mode_n   = MODE_TRACK;
          result_n = acc_n;
          valid_n  = 1'b1;
        end else begin
          step_n = step_q >> 1;
        end
      end else begin
        acc_n = trial_q;
        if (cont) begin
          if (up_q && (trial_q == period_i)) begin
            step_n   = ONE;
            grow_n   = 1'b1;
            result_n = trial_q;
            valid_n  = 1'b1;
          end else if (!up_q && (trial_q == '0)) begin
            step_n = ONE;
          end else begin
            step_n = grow_q ? dbl : step_q;
          end
        end else begin
          up_n   = ~up_q;
          step_n = ONE;
          grow_n = (step_q == ONE);
          if (step_q == ONE) begin
            valid_n  = 1'b1;
            result_n = up_q ? acc_q : trial_q;
          end
        end
      end
    end
  end

  always_comb begin
    sum     = {1'b0, acc_n} + {1'b0, step_n};
    trial_n = trial_q;
    if (apply || decide) begin
      if (up_n) trial_n = (sum > {1'b0, period_i}) ? period_i : sum[CNT_W-1:0];
      else      trial_n = (acc_n > step_n) ? (acc_n - step_n) : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_SEARCH;
      acc_q    <= '0;
      step_q   <= MID;
      trial_q  <= '0;
      result_q <= '0;
      wcnt_q   <= '0;
      up_q     <= 1'b1;
      grow_q   <= 1'b1;
      pend_q   <= 1'b1;
      valid_q  <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      acc_q    <= acc_n;
      step_q   <= step_n;
      trial_q  <= trial_n;
      result_q <= result_n;
      up_q     <= up_n;
      grow_q   <= grow_n;
      valid_q  <= valid_n;
      pend_q   <= start_i | (pend_q & ~wrap_i);
      if (wrap_i) wcnt_q <= (apply || decide) ? '0 : wcnt_q + 1'b1;
    end
  end

  assign trial_next_o = trial_n;
  assign step_o       = step_q;
  assign decide_o     = decide;
  assign result_o     = result_q;
  assign valid_o      = valid_q;
endmodule

// File: rtl/pwm_sar_tracker.sv
module pwm_sar_tracker #(
  parameter int CNT_W       = 16,
  parameter int SET_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic             cmp_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o
);
  logic             wrap_w;
  logic             cmp_s;
  logic             decide_w;
  logic [CNT_W-1:0] duty_w;
  logic [CNT_W-1:0] trial_next_w;
  logic [CNT_W-1:0] step_w;

  pwm_sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_i),
    .q_o    (cmp_s)
  );

  pwm_sar_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .period_i    (period_i),
    .duty_next_i (trial_next_w),
    .wrap_o      (wrap_w),
    .duty_o      (duty_w),
    .pwm_o       (pwm_o)
  );

  pwm_sar_ctrl #(.CNT_W(CNT_W), .SET_W(SET_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wrap_i       (wrap_w),
    .start_i      (start_i),
    .cmp_i        (cmp_s),
    .period_i     (period_i),
    .settle_i     (settle_i),
    .trial_next_o (trial_next_w),
    .step_o       (step_w),
    .decide_o     (decide_w),
    .result_o     (result_o),
    .valid_o      (valid_o)
  );
endmodule

// File: rtl/pwm_sar_tracker_chk.sv
module pwm_sar_tracker_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] period_i,
  input logic             pwm_o,
  input logic             valid_o,
  input logic [CNT_W-1:0] result_o,
  input logic             wrap_w,
  input logic             decide_w,
  input logic [CNT_W-1:0] duty_w,
  input logic [CNT_W-1:0] step_w
);
  // R2
  pwm_rise_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> $past(wrap_w));

  // R2
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_w |=> $stable(duty_w));

  // R9
  duty_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_w <= period_i);

  // R6
  step_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(step_w) == 1);

  // R11
  valid_after_decide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(decide_w));

  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
endmodule

bind pwm_sar_tracker pwm_sar_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .period_i (period_i),
  .pwm_o    (pwm_o),
  .valid_o  (valid_o),
  .result_o (result_o),
  .wrap_w   (wrap_w),
  .decide_w (decide_w),
  .duty_w   (duty_w),
  .step_w   (step_w)
);

// File: tb/tb_pwm_sar_tracker.sv
module tb_pwm_sar_tracker;
  localparam int CW   = 6;
  localparam int SW   = 3;
  localparam int PER  = 63;
  localparam int SET  = 2;
  localparam int MID  = 1 << (CW-1);
  localparam int WIN  = (SET+1)*(PER+1);
  localparam int CONV = (PER+1)*(1+CW*(SET+1));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cmp = 1'b0;
  logic [CW-1:0] period = CW'(PER);
  logic [SW-1:0] settle = SW'(SET);
  logic          pwm;
  logic [CW-1:0] res;
  logic          val;

  int n_chk = 0;
  int n_bad = 0;
  int vin = 37;

  pwm_sar_tracker #(.CNT_W(CW), .SET_W(SW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .period_i(period),
    .settle_i(settle), .cmp_i(cmp), .pwm_o(pwm), .result_o(res), .valid_o(val)
  );

  always #10 clk = ~clk;

  // behavioural reference, advanced on each edge from the inputs held since the last negedge
  int m_cnt, m_duty, m_pwm, m_s1, m_s2, m_pend, m_wcnt, m_mode, m_up, m_grow;
  int m_acc, m_step, m_trial, m_res, m_val;
  int n_acc, n_step, n_up, n_grow, n_mode, n_trial;
  bit wr, ap, de, c;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_duty = 0; m_pwm = 0; m_s1 = 0; m_s2 = 0; m_pend = 1; m_wcnt = 0;
      m_mode = 0; m_up = 1; m_grow = 1; m_acc = 0; m_step = MID; m_trial = 0;
      m_res = 0; m_val = 0;
    end else begin
      wr = (m_cnt >= PER);
      ap = wr && (m_pend != 0);
      de = wr && (m_pend == 0) && (m_wcnt >= SET);
      c  = (m_s2 != 0);
      n_acc = m_acc; n_step = m_step; n_up = m_up; n_grow = m_grow; n_mode = m_mode;
      m_val = 0;
      if (ap) begin
        n_acc = 0; n_step = MID; n_up = 1; n_grow = 1; n_mode = 0;
      end else if (de) begin
        if (m_mode == 0) begin
          n_acc = c ? m_acc : m_trial;
          if (m_step == 1) begin n_mode = 1; m_res = n_acc; m_val = 1; end
          else n_step = m_step / 2;
        end else begin
          n_acc = m_trial;
          if ((m_up != 0) != c) begin
            if (m_up != 0 && m_trial == PER) begin
              n_step = 1; n_grow = 1; m_res = m_trial; m_val = 1;
            end else if (m_up == 0 && m_trial == 0) n_step = 1;
            else if (m_grow != 0) n_step = (m_step * 2 > MID) ? MID : m_step * 2;
          end else begin
            n_up = (m_up != 0) ? 0 : 1;
            n_step = 1;
            n_grow = (m_step == 1) ? 1 : 0;
            if (m_step == 1) begin m_val = 1; m_res = (m_up != 0) ? m_acc : m_trial; end
          end
        end
      end
      n_trial = m_trial;
      if (ap || de) begin
        if (n_up != 0) n_trial = (n_acc + n_step > PER) ? PER : n_acc + n_step;
        else           n_trial = (n_acc > n_step) ? n_acc - n_step : 0;
      end
      m_pend = (start || (m_pend != 0 && !wr)) ? 1 : 0;
      if (wr) m_wcnt = (ap || de) ? 0 : m_wcnt + 1;
      if (wr) m_duty = n_trial;
      m_cnt = wr ? 0 : m_cnt + 1;
      m_pwm = (m_cnt < m_duty) ? 1 : 0;
      m_s2 = m_s1; m_s1 = cmp ? 1 : 0;
      m_acc = n_acc; m_step = n_step; m_up = n_up; m_grow = n_grow; m_mode = n_mode;
      m_trial = n_trial;
    end
  end

  // per-clock comparison and external filter/comparator model
  int hcnt = 0;
  int pidx = 0;
  int first_hc = -1;
  int prev_pwm = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      hcnt = 0; pidx = 0; prev_pwm = 0;
    end else begin
      n_chk += 3;
      if (int'(pwm) != m_pwm) begin
        n_bad++; $display("FAIL R1 pwm actual=%0d expected=%0d", pwm, m_pwm);
      end
      if (int'(res) != m_res) begin
        n_bad++; $display("FAIL R4 result actual=%0d expected=%0d", res, m_res);
      end
      if (int'(val) != m_val) begin
        n_bad++; $display("FAIL R11 valid actual=%0d expected=%0d", val, m_val);
      end
      if (pwm && prev_pwm == 0) begin
        n_chk++;
        if (m_cnt != 0) begin
          n_bad++; $display("FAIL R2 rise at count actual=%0d expected=0", m_cnt);
        end
      end
      prev_pwm = pwm;
      hcnt += pwm;
      if (m_cnt >= PER) begin
        pidx++;
        if (pidx == 2) first_hc = hcnt;
        cmp = (hcnt > vin);
        hcnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!val && cyc < 4*CONV);
  endtask

  task automatic wait_res(input int target, input int limit, input string tag);
    int n = 0;
    bit found = 0;
    while (!found && n < limit) begin
      @(negedge clk);
      n++;
      if (val && int'(res) == target) found = 1;
    end
    check(found, tag, int'(res), target);
  endtask

  task automatic finish_all();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_all();
  end

  initial begin
    int cyc;
    repeat (5) @(negedge clk);
    // R3 reset state
    check(pwm == 1'b0, "R3 pwm in reset", int'(pwm), 0);
    check(val == 1'b0, "R3 valid in reset", int'(val), 0);
    check(res == '0, "R3 result in reset", int'(res), 0);
    rst_n = 1'b1;

    // R5 first search latency, R4 result and mid-scale first trial
    wait_valid(cyc);
    check(cyc == CONV, "R5 first result latency", cyc, CONV);
    check(int'(res) == 37, "R4 search result", int'(res), 37);
    check(first_hc == MID, "R4 first trial high time", first_hc, MID);

    // R7 steady input: one strobe per window, same code
    wait_valid(cyc);
    check(cyc == WIN, "R7 steady strobe spacing", cyc, WIN);
    check(int'(res) == 37, "R7 steady result", int'(res), 37);
    wait_valid(cyc);
    check(cyc == WIN && int'(res) == 37, "R7 steady repeat", int'(res), 37);

    // R6 and R8: step up with overshoot must converge
    vin = 40;
    wait_res(40, 30*WIN, "R8 converge after overshoot");
    for (int v = 41; v <= 44; v++) begin
      vin = v;
      wait_res(v, 10*WIN, "R6 slow upward ramp");
    end
    vin = 42;
    wait_res(42, 10*WIN, "R6 slow downward move");

    // R9 saturation at both ends
    vin = PER;
    wait_res(PER, 40*WIN, "R9 top of range");
    wait_valid(cyc);
    check(cyc == WIN && int'(res) == PER, "R9 held at top", int'(res), PER);
    vin = 0;
    wait_res(0, 40*WIN, "R9 bottom of range");
    vin = 20;
    wait_res(20, 40*WIN, "R6 large upward jump");

    // R10 restart from tracking
    wait_valid(cyc);
    vin = 50;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!val && cyc < 4*CONV) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == CONV, "R10 restart latency", cyc, CONV);
    check(int'(res) == 50, "R10 restart result", int'(res), 50);

    finish_all();
  end
endmodule